// File: doc/BRIEF.md
# Nested Multi-Tier Interrupt Priority Controller

This block sits between a set of interrupt sources and a processor core. It sorts every pending request into one of five tiers, from lowest to highest: a low software tier, three programmable tiers and a top tier. It then picks a single winner and hands the core three things: a vector address, the winner's tier, and a flag saying whether the winner reached the core through one of two fast-interrupt slots. Ordinary peripheral sources each carry a two-bit priority field. The top tier holds two kinds of source. Trap sources cannot be masked. Debug-event sources obey the core's mask.

The core supplies a mask threshold. It also says whether a handler is running and at what tier, so the block only forwards a request that is allowed to nest over the running handler. A wake output tells the clock controller that some enabled request is pending, whatever the mask says. The vector table base is an input, so the table can be moved. Each of the two fast slots holds a source index and its own handler address.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after reset is sampled, `irq_valid`, `irq_fast` and `wake_req` are 0, and `irq_vec` and `irq_level` are 0.
- R2: The priority field of ordinary source k is `dev_prio[2k+1:2k]`. A value of 0 disables the source: it raises neither `irq_valid` nor `wake_req`. Values 1, 2 and 3 put the source in tier codes 1, 2 and 3.
- R3: `irq_level` uses these codes: 0 for the low software tier, 1 to 3 for the programmable tiers, 4 for the top tier. Among the requests that may be forwarded, the one with the highest code wins.
- R4: Within one tier, the lower source index wins. Indices are laid out as follows: traps 0..NUM_TRAP-1, then debug events, then ordinary sources, then the low software request last. With the default parameters these ranges are 0-3, 4-6, 7-22 and 23.
- R5: A maskable request is forwarded only if its tier code is greater than or equal to `core_mask`.
- R6: Trap requests are forwarded whatever `core_mask` holds. Debug-event requests are tier 4 and are masked like any other maskable source.
- R7: While `svc_active` is 1, a request is forwarded only if its tier code is strictly greater than `svc_level`. This applies to traps as well.
- R8: For a winner that is not fast, `irq_vec` equals `vec_base + 2 * index`.
- R9: If `fast_on[0]` is set and `fast_sel0` equals the winner's index, then `irq_fast` is 1 and `irq_vec` is `fast_vec0`. Otherwise the same test is made for slot 1. Slot 0 wins when both slots name the winner. A slot whose enable bit is clear has no effect.
- R10: `wake_req` is 1 whenever any enabled request is pending, even when the mask or nesting rule blocks it.
- R11: All outputs are registered: they reflect the inputs sampled at the previous rising edge. While `irq_valid` is 0, `irq_vec`, `irq_level` and `irq_fast` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | NUM_TRAP | Unmaskable top-tier requests |
| dbg_req | input | NUM_DBG | Maskable top-tier debug-event requests |
| dev_req | input | NUM_DEV | Ordinary source requests |
| dev_prio | input | 2*NUM_DEV | Per-source priority field, 0 = disabled |
| swlow_req | input | 1 | Lowest-tier software request |
| vec_base | input | ADDR_W | Vector table base |
| fast_on | input | 2 | Fast slot enables |
| fast_sel0 | input | IDX_W | Source index in fast slot 0 |
| fast_sel1 | input | IDX_W | Source index in fast slot 1 |
| fast_vec0 | input | ADDR_W | Handler address for fast slot 0 |
| fast_vec1 | input | ADDR_W | Handler address for fast slot 1 |
| core_mask | input | 3 | Core mask threshold (tier code) |
| svc_active | input | 1 | A handler is running |
| svc_level | input | 3 | Tier code of the running handler |
| irq_valid | output | 1 | A request is presented to the core |
| irq_vec | output | ADDR_W | Vector address of the winner |
| irq_level | output | 3 | Tier code of the winner |
| irq_fast | output | 1 | The winner is served through a fast slot |
| wake_req | output | 1 | An enabled request is pending |

## Verification
Every result appears exactly one rising edge after the inputs that caused it. Vector, tier, fast flag and wake all come from the same registered stage, so they share that one-edge delay. The driver applies each input set at a falling edge and stamps the expected result with the cycle count of the next rising edge. The monitor compares only at the falling edge where the cycle counter matches that stamp, which is half a period after the output register has updated. Directed cases cover each tier boundary, the mask and nesting edges (equal against strictly greater), the fast-slot collisions and relocation of the vector base. A long random run then mixes all inputs.

// File: rtl/irq_nest_pkg.sv
// Shared tier codes for the nested interrupt controller.
// Assumes tier codes are ordered so a numeric compare gives priority.
package irq_nest_pkg;
    localparam int N_TIERS = 5;
    localparam logic [2:0] TIER_SWLOW = 3'd0;
    localparam logic [2:0] TIER_TOP   = 3'd4;
endpackage

// File: rtl/irq_level_map.sv
// Maps every source to a tier code and decides whether it may be forwarded.
// Applies the enable, mask and nesting rules.
// Assumes a source index order of traps, debug events, ordinary sources, low software.
module irq_level_map
    import irq_nest_pkg::*;
#(
    parameter int NUM_TRAP = 4,
    parameter int NUM_DBG  = 3,
    parameter int NUM_DEV  = 16,
    localparam int NUM_ALL = NUM_TRAP + NUM_DBG + NUM_DEV + 1,
    localparam int DEV_OFS = NUM_TRAP + NUM_DBG
) (
    input  logic [NUM_TRAP-1:0]               trap_req,
    input  logic [NUM_DBG-1:0]                dbg_req,
    input  logic [NUM_DEV-1:0]                dev_req,
    input  logic [2*NUM_DEV-1:0]              dev_prio,
    input  logic                              swlow_req,
    input  logic [2:0]                        core_mask,
    input  logic                              svc_active,
    input  logic [2:0]                        svc_level,
    output logic [N_TIERS-1:0][NUM_ALL-1:0]   cand,
    output logic                              pend_any
);
    logic [NUM_ALL-1:0][2:0] tier;
    logic [NUM_ALL-1:0]      pend;
    logic [NUM_ALL-1:0]      nomask;
    logic [NUM_ALL-1:0]      fwd;

    // Trap sources: top tier, never masked.
    for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap
        assign tier[t]   = TIER_TOP;
        assign pend[t]   = trap_req[t];
        assign nomask[t] = 1'b1;
    end

    // Debug-event sources: top tier, masked.
    for (genvar d = 0; d < NUM_DBG; d++) begin : g_dbg
        assign tier[NUM_TRAP+d]   = TIER_TOP;
        assign pend[NUM_TRAP+d]   = dbg_req[d];
        assign nomask[NUM_TRAP+d] = 1'b0;
    end

    // Ordinary sources: field 0 disables, 1..3 are tier codes 1..3.
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
        assign tier[DEV_OFS+k]   = {1'b0, dev_prio[2*k +: 2]};
        assign pend[DEV_OFS+k]   = dev_req[k] && (dev_prio[2*k +: 2] != 2'd0);
        assign nomask[DEV_OFS+k] = 1'b0;
    end

    // Low software request occupies the last index.
    assign tier[NUM_ALL-1]   = TIER_SWLOW;
    assign pend[NUM_ALL-1]   = swlow_req;
    assign nomask[NUM_ALL-1] = 1'b0;

    // Forwarding gate: mask threshold plus strict nesting over the running handler.
    for (genvar i = 0; i < NUM_ALL; i++) begin : g_fwd
        assign fwd[i] = pend[i]
                     && (nomask[i] || (tier[i] >= core_mask))
                     && (!svc_active || (tier[i] > svc_level));
    end

    // Split forwarded requests into one vector per tier.
    for (genvar r = 0; r < N_TIERS; r++) begin : g_tier
        for (genvar i = 0; i < NUM_ALL; i++) begin : g_src
            assign cand[r][i] = fwd[i] && (tier[i] == 3'(r));
        end
    end

    assign pend_any = |pend;
endmodule

// File: rtl/irq_arbiter.sv
// Chooses the highest non-empty tier, then the lowest index inside it.
// Assumes the candidate vectors are already gated by mask and nesting.
module irq_arbiter
    import irq_nest_pkg::*;
#(
    parameter int NUM_ALL = 24,
    localparam int IDX_W = $clog2(NUM_ALL)
) (
    input  logic [N_TIERS-1:0][NUM_ALL-1:0] cand,
    output logic                            hit,
    output logic [IDX_W-1:0]                win_idx,
    output logic [2:0]                      win_tier
);
    // Scan tiers upward so the highest one overwrites; scan indices downward so the lowest wins.
    always_comb begin
        hit      = 1'b0;
        win_idx  = '0;
        win_tier = '0;
        for (int r = 0; r < N_TIERS; r++) begin
            if (|cand[r]) begin
                hit      = 1'b1;
                win_tier = 3'(r);
                for (int i = NUM_ALL - 1; i >= 0; i--) begin
                    if (cand[r][i]) win_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/irq_vector_gen.sv
// Forms the handler address of the winner: a fast-slot address, or base plus stride times index.
// Assumes slot 0 takes precedence over slot 1.
module irq_vector_gen #(
    parameter int ADDR_W     = 16,
    parameter int IDX_W      = 5,
    parameter int VEC_STRIDE = 2
) (
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [ADDR_W-1:0] vec_base,
    input  logic [1:0]        fast_on,
    input  logic [IDX_W-1:0]  fast_sel0,
    input  logic [IDX_W-1:0]  fast_sel1,
    input  logic [ADDR_W-1:0] fast_vec0,
    input  logic [ADDR_W-1:0] fast_vec1,
    output logic [ADDR_W-1:0] vec,
    output logic              fast
);
    logic hit0, hit1;
    logic [ADDR_W-1:0] table_addr;

    assign hit0       = fast_on[0] && (fast_sel0 == win_idx);
    assign hit1       = fast_on[1] && (fast_sel1 == win_idx);
    assign table_addr = vec_base + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE);

    // Select the dedicated slot address or the table entry.
    always_comb begin
        fast = hit0 || hit1;
        if (hit0)      vec = fast_vec0;
        else if (hit1) vec = fast_vec1;
        else           vec = table_addr;
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
// Top of the nested multi-tier interrupt controller.
// Maps sources to tiers, arbitrates, forms the vector and registers all outputs.
// Assumes core_mask, svc_active and svc_level are valid every cycle.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_TRAP   = 4,
    parameter int NUM_DBG    = 3,
    parameter int NUM_DEV    = 16,
    parameter int ADDR_W     = 16,
    parameter int VEC_STRIDE = 2,
    localparam int NUM_ALL   = NUM_TRAP + NUM_DBG + NUM_DEV + 1,
    localparam int IDX_W     = $clog2(NUM_ALL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_TRAP-1:0]   trap_req,
    input  logic [NUM_DBG-1:0]    dbg_req,
    input  logic [NUM_DEV-1:0]    dev_req,
    input  logic [2*NUM_DEV-1:0]  dev_prio,
    input  logic                  swlow_req,
    input  logic [ADDR_W-1:0]     vec_base,
    input  logic [1:0]            fast_on,
    input  logic [IDX_W-1:0]      fast_sel0,
    input  logic [IDX_W-1:0]      fast_sel1,
    input  logic [ADDR_W-1:0]     fast_vec0,
    input  logic [ADDR_W-1:0]     fast_vec1,
    input  logic [2:0]            core_mask,
    input  logic                  svc_active,
    input  logic [2:0]            svc_level,
    output logic                  irq_valid,
    output logic [ADDR_W-1:0]     irq_vec,
    output logic [2:0]            irq_level,
    output logic                  irq_fast,
    output logic                  wake_req
);
    logic [N_TIERS-1:0][NUM_ALL-1:0] cand;
    logic                            pend_any;
    logic                            hit;
    logic [IDX_W-1:0]                win_idx;
    logic [2:0]                      win_tier;
    logic [ADDR_W-1:0]               nxt_vec;
    logic                            nxt_fast;

    irq_level_map #(.NUM_TRAP(NUM_TRAP), .NUM_DBG(NUM_DBG), .NUM_DEV(NUM_DEV)) u_map (
        .trap_req(trap_req), .dbg_req(dbg_req), .dev_req(dev_req), .dev_prio(dev_prio),
        .swlow_req(swlow_req), .core_mask(core_mask), .svc_active(svc_active),
        .svc_level(svc_level), .cand(cand), .pend_any(pend_any)
    );

    irq_arbiter #(.NUM_ALL(NUM_ALL)) u_arb (
        .cand(cand), .hit(hit), .win_idx(win_idx), .win_tier(win_tier)
    );

    irq_vector_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VEC_STRIDE(VEC_STRIDE)) u_vec (
        .win_idx(win_idx), .vec_base(vec_base), .fast_on(fast_on),
        .fast_sel0(fast_sel0), .fast_sel1(fast_sel1),
        .fast_vec0(fast_vec0), .fast_vec1(fast_vec1),
        .vec(nxt_vec), .fast(nxt_fast)
    );

    // Output register; fields are zeroed when nothing is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_vec   <= '0;
            irq_level <= '0;
            irq_fast  <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            irq_valid <= hit;
            irq_vec   <= hit ? nxt_vec : '0;
            irq_level <= hit ? win_tier : '0;
            irq_fast  <= hit && nxt_fast;
            wake_req  <= pend_any;
        end
    end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
// Property checker for irq_nest_ctrl, attached by bind.
// Assumes outputs are registered one edge after the inputs they reflect.
module irq_nest_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        core_mask,
    input logic              svc_active,
    input logic [2:0]        svc_level,
    input logic [ADDR_W-1:0] fast_vec0,
    input logic [ADDR_W-1:0] fast_vec1,
    input logic              irq_valid,
    input logic [ADDR_W-1:0] irq_vec,
    input logic [2:0]        irq_level,
    input logic              irq_fast,
    input logic              wake_req
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!irq_valid && !irq_fast && !wake_req));

    a_r5_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_level != 3'd4) |-> (irq_level >= $past(core_mask)));

    a_r7_strict_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && $past(svc_active)) |-> (irq_level > $past(svc_level)));

    a_r10_wake_covers_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> wake_req);

    a_r9_fast_uses_slot_addr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (irq_vec == $past(fast_vec0) || irq_vec == $past(fast_vec1)));

    a_r11_idle_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vec == '0 && irq_level == 3'd0 && !irq_fast));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_mask(core_mask), .svc_active(svc_active),
    .svc_level(svc_level), .fast_vec0(fast_vec0), .fast_vec1(fast_vec1),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_level(irq_level),
    .irq_fast(irq_fast), .wake_req(wake_req)
);

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;
    localparam int NT = 4, ND = 3, NV = 16, AW = 16;
    localparam int NA = NT + ND + NV + 1;
    localparam int IW = $clog2(NA);

    logic clk = 1'b0;
    logic rst_n;
    logic [NT-1:0] trap_req;
    logic [ND-1:0] dbg_req;
    logic [NV-1:0] dev_req;
    logic [2*NV-1:0] dev_prio;
    logic swlow_req;
    logic [AW-1:0] vec_base;
    logic [1:0] fast_on;
    logic [IW-1:0] fast_sel0, fast_sel1;
    logic [AW-1:0] fast_vec0, fast_vec1;
    logic [2:0] core_mask;
    logic svc_active;
    logic [2:0] svc_level;
    logic irq_valid, irq_fast, wake_req;
    logic [AW-1:0] irq_vec;
    logic [2:0] irq_level;

    irq_nest_ctrl u_irq_nest_ctrl (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        logic valid; logic [AW-1:0] vec; logic [2:0] lvl;
        logic fast; logic wake; int due; string tag;
    } exp_t;
    exp_t sb[$];
    int cyc = 0, checks = 0, fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference built from the requirements.
    task automatic model(input string tag, output exp_t e);
        int best_r = -1, best_i = 0;
        logic wk = 0;
        for (int i = 0; i < NA; i++) begin
            int r; logic p; logic um;
            um = 0;
            if (i < NT) begin r = 4; p = trap_req[i]; um = 1; end
            else if (i < NT + ND) begin r = 4; p = dbg_req[i-NT]; end
            else if (i < NA - 1) begin
                r = int'(dev_prio[2*(i-NT-ND) +: 2]);
                p = dev_req[i-NT-ND] && (r != 0);
            end else begin r = 0; p = swlow_req; end
            if (p) wk = 1;
            if (p && (um || r >= int'(core_mask)) && (!svc_active || r > int'(svc_level))
                && r > best_r) begin
                best_r = r; best_i = i;
            end
        end
        e.tag = tag; e.due = cyc + 1;
        e.valid = (best_r >= 0); e.wake = wk; e.fast = 0; e.vec = '0; e.lvl = '0;
        if (e.valid) begin
            e.lvl = 3'(best_r);
            if (fast_on[0] && int'(fast_sel0) == best_i) begin e.fast = 1; e.vec = fast_vec0; end
            else if (fast_on[1] && int'(fast_sel1) == best_i) begin e.fast = 1; e.vec = fast_vec1; end
            else e.vec = vec_base + AW'(best_i * 2);
        end
        if (!rst_n) begin e.valid = 0; e.wake = 0; e.fast = 0; e.vec = '0; e.lvl = '0; end
    endtask

    // Driver: called at a falling edge, queues the expectation, steps one cycle.
    task automatic apply(input string tag);
        exp_t e;
        model(tag, e);
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic clear_in();
        trap_req = '0; dbg_req = '0; dev_req = '0; dev_prio = '0; swlow_req = 0;
        vec_base = 16'h1000; fast_on = '0; fast_sel0 = '0; fast_sel1 = '0;
        fast_vec0 = 16'hA000; fast_vec1 = 16'hB000;
        core_mask = '0; svc_active = 0; svc_level = '0;
    endtask

    task automatic set_prio(input int k, input logic [1:0] p);
        dev_prio[2*k +: 2] = p;
    endtask

    // Monitor: compares the result due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_valid !== e.valid || irq_vec !== e.vec || irq_level !== e.lvl
                || irq_fast !== e.fast || wake_req !== e.wake) begin
                fails++;
                $display("FAIL %s: got v=%0b vec=%h lvl=%0d fast=%0b wake=%0b, exp v=%0b vec=%h lvl=%0d fast=%0b wake=%0b",
                         e.tag, irq_valid, irq_vec, irq_level, irq_fast, wake_req,
                         e.valid, e.vec, e.lvl, e.fast, e.wake);
            end
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        trap_req = 4'b0001; dev_req = '1; dev_prio = '1;
        @(negedge clk);
        apply("R1 reset dominates");
        apply("R1 reset dominates");
        clear_in();
        rst_n = 1;
        apply("R11 idle after reset");

        dev_req[5] = 1; set_prio(5, 2'd0);
        apply("R2 disabled source");
        set_prio(5, 2'd2);
        apply("R2 field 2 gives tier 2, R8 vec");
        clear_in(); dev_req[3] = 1; set_prio(3, 2'd1); dev_req[9] = 1; set_prio(9, 2'd3);
        apply("R3 higher tier wins");
        dbg_req[1] = 1;
        apply("R3 top tier beats tier 3");
        clear_in(); dev_req[2] = 1; dev_req[6] = 1; set_prio(2, 2'd2); set_prio(6, 2'd2);
        apply("R4 lower ordinary index wins");
        clear_in(); trap_req = 4'b1010;
        apply("R4 lower trap index wins");
        clear_in(); dev_req[4] = 1; set_prio(4, 2'd2); core_mask = 3'd3;
        apply("R5 below mask blocked, R10 wake");
        core_mask = 3'd2;
        apply("R5 equal to mask passes");
        clear_in(); core_mask = 3'd5; dbg_req = 3'b100;
        apply("R6 debug event masked");
        trap_req[2] = 1;
        apply("R6 trap ignores mask");
        clear_in(); svc_active = 1; svc_level = 3'd2; dev_req[0] = 1; set_prio(0, 2'd2);
        apply("R7 equal tier does not nest");
        set_prio(0, 2'd3);
        apply("R7 higher tier nests");
        clear_in(); svc_active = 1; svc_level = 3'd4; trap_req[0] = 1;
        apply("R7 trap blocked by running top handler");
        clear_in(); vec_base = 16'h4000; swlow_req = 1;
        apply("R8 relocated base, low tier");
        clear_in(); dev_req[5] = 1; set_prio(5, 2'd1); fast_on = 2'b01; fast_sel0 = 5'd12;
        apply("R9 slot 0 fast");
        fast_on = 2'b11; fast_sel1 = 5'd12;
        apply("R9 slot 0 wins collision");
        fast_on = 2'b10; fast_sel1 = 5'd12;
        apply("R9 slot 1 fast");
        fast_on = 2'b00;
        apply("R9 disabled slots ignored");
        clear_in(); dev_req = '1;
        apply("R10 no wake when all disabled");

        for (int n = 0; n < 400; n++) begin
            trap_req  = ($urandom_range(0, 7) == 0) ? NT'($urandom) : '0;
            dbg_req   = ($urandom_range(0, 3) == 0) ? ND'($urandom) : '0;
            dev_req   = NV'($urandom) & NV'($urandom);
            dev_prio  = 32'($urandom);
            swlow_req = 1'($urandom);
            vec_base  = AW'($urandom);
            fast_on   = 2'($urandom);
            fast_sel0 = IW'($urandom_range(0, NA - 1));
            fast_sel1 = IW'($urandom_range(0, NA - 1));
            fast_vec0 = AW'($urandom);
            fast_vec1 = AW'($urandom);
            core_mask = 3'($urandom_range(0, 5));
            svc_active = 1'($urandom);
            svc_level = 3'($urandom_range(0, 4));
            apply("R3 R4 R9 random mix");
        end
        clear_in();
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R11: %0d results never compared, expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11: watchdog expired, got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule